// File: doc/BRIEF.md
# Paged monochrome LCD frame buffer

This block holds the pixel memory of a 128 by 64 monochrome panel. The memory is split into eight horizontal bands (pages), each eight pixel rows tall and 128 columns wide. Each stored byte covers one column of one page. Bit k of that byte is the pixel in row k of the band, and a 1 means the pixel is lit. A host drives a simple register write port. It first puts the block into command or data mode through a mode register. In command mode, instruction bytes choose the page. In data mode, pixel bytes are stored at the current page and column, and the column then advances.

A display engine refreshes the panel through a separate scan-out port. It presents an x,y coordinate and gets back the single pixel bit one clock later. The scan port and host writes work at the same time and do not wait for each other. Column count and page count are parameters. The defaults give the 128x64 panel with a 1024-byte store.

Top module: `mono_fb_ctrl`

## Requirements
- R1: After reset the mode is invalid, so the mode register (offset 0x1AC) reads 0. The cursor is at page 0, column 0, and changing the mode does not move it.
- R2: Writing exactly 0x00100011 to offset 0x1AC selects data mode. The register then reads back 0x00100011.
- R3: Writing exactly 0x00104011 to offset 0x1AC selects command mode. The register then reads back 0x00104011.
- R4: Writing any other value to offset 0x1AC makes the mode invalid, and the register reads 0.
- R5: Writing 0xB0+n (n from 0 to 7) to the instruction register at offset 0x1BC selects page n and sets the column to 0, in any mode. Any other value written there leaves the cursor unchanged.
- R6: In command mode, writing 0xB0+n to the data register at offset 0x1C0 selects page n and sets the column to 0. Other values written there in command mode store nothing and leave the cursor unchanged.
- R7: In data mode, a write to offset 0x1C0 stores bits 7..0 of the write data at the current page and column, and the column then increases by one.
- R8: The column wraps from 127 to 0 and stays on the same page, so byte 129 of a run overwrites column 0 of that page.
- R9: In invalid mode, writes to the data register store nothing and do not move the cursor.
- R10: The scan-out pixel for coordinate (x,y) is bit (y mod 8) of the byte at column x of page y/8. It appears one clock after the coordinate is presented.
- R11: Every offset other than 0x1AC reads 0, including 0x180, 0x184, 0x1BC and 0x1C0.
- R12: The scan-out port returns a correct pixel in every cycle, including cycles in which the host writes pixel data to another location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host register write strobe |
| bus_addr | input | OFS_W | Host register byte offset, used for both writes and reads |
| bus_wdata | input | DW | Host write data |
| bus_rdata | output | DW | Read data for bus_addr (combinational) |
| scan_x | input | clog2(COLS) | Scan-out column |
| scan_y | input | clog2(PAGES)+3 | Scan-out row |
| scan_pix | output | 1 | Pixel bit for the coordinate of the previous cycle |

## Verification
The assertions assume one register access per cycle at a single offset. They also assume the scan coordinate stays within the panel. The stimulus writes one register per clock and only scans rows and columns that exist. It never scans a location in the same cycle as a write to it, because such a scan returns the old byte. It reads back only bytes it wrote earlier, since the pixel store has no reset value.

// File: rtl/fb_pkg.sv
package fb_pkg;
   typedef enum logic [1:0] {
      FB_MODE_INVALID = 2'd0,
      FB_MODE_DATA    = 2'd1,
      FB_MODE_CMD     = 2'd2
   } fb_mode_e;

   localparam logic [31:0] FB_DATA_WORD = 32'h0010_0011;
   localparam logic [31:0] FB_CMD_WORD  = 32'h0010_4011;
   localparam logic [31:0] FB_PAGE_OP   = 32'h0000_00B0;
endpackage

// File: rtl/fb_mode_reg.sv
module fb_mode_reg
   import fb_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   output fb_mode_e      mode
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         mode <= FB_MODE_INVALID;
      else if (wr) begin
         if (wdata == DW'(FB_DATA_WORD))
            mode <= FB_MODE_DATA;
         else if (wdata == DW'(FB_CMD_WORD))
            mode <= FB_MODE_CMD;
         else
            mode <= FB_MODE_INVALID;
      end
   end

   assert_bad_word_invalid_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wdata != DW'(FB_DATA_WORD) && wdata != DW'(FB_CMD_WORD))
      |=> mode == FB_MODE_INVALID);

   assert_mode_held_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(mode));
endmodule

// File: rtl/fb_cursor.sv
module fb_cursor
   import fb_pkg::*;
#(
   parameter int COLS  = 128,
   parameter int PAGES = 8,
   parameter int DW    = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     inst_wr,
   input  logic                     data_wr,
   input  logic [DW-1:0]            wdata,
   input  fb_mode_e                 mode,
   output logic [$clog2(PAGES)-1:0] page,
   output logic [$clog2(COLS)-1:0]  col,
   output logic                     store_en
);
   localparam int COL_W  = $clog2(COLS);
   localparam int PAGE_W = $clog2(PAGES);

   logic is_page_op;
   logic page_sel;
   logic [DW-1:0] page_idx;

   always_comb begin
      page_idx   = wdata - DW'(FB_PAGE_OP);
      is_page_op = (wdata >= DW'(FB_PAGE_OP)) && (page_idx < DW'(PAGES));
      page_sel   = is_page_op && (inst_wr || (data_wr && mode == FB_MODE_CMD));
      store_en   = data_wr && mode == FB_MODE_DATA;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page <= '0;
         col  <= '0;
      end else if (page_sel) begin
         page <= page_idx[PAGE_W-1:0];
         col  <= '0;
      end else if (store_en) begin
         col <= col + 1'b1;
      end
   end

   assert_sel_clears_col_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (inst_wr && is_page_op) |=> col == '0);

   assert_col_steps_wraps_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && mode == FB_MODE_DATA) |=> col == COL_W'($past(col) + 1'b1));

   assert_invalid_holds_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (!inst_wr && mode == FB_MODE_INVALID) |=> ($stable(col) && $stable(page)));
endmodule

// File: rtl/fb_store.sv
module fb_store #(
   parameter int COLS  = 128,
   parameter int PAGES = 8
) (
   input  logic                       clk,
   input  logic                       we,
   input  logic [$clog2(PAGES)-1:0]   page,
   input  logic [$clog2(COLS)-1:0]    col,
   input  logic [7:0]                 wbyte,
   input  logic [$clog2(COLS)-1:0]    scan_x,
   input  logic [$clog2(PAGES)+2:0]   scan_y,
   output logic                       scan_pix
);
   localparam int PAGE_W = $clog2(PAGES);
   localparam int ROW_W  = PAGE_W + 3;

   logic [PAGES-1:0] we_vec;
   logic [7:0]       col_byte [PAGES];
   logic [7:0]       sel_byte;

   for (genvar p = 0; p < PAGES; p++) begin : g_page
      logic [7:0] bank [COLS];
      assign we_vec[p]   = we && (page == PAGE_W'(p));
      assign col_byte[p] = bank[scan_x];
      always_ff @(posedge clk) begin
         if (we_vec[p])
            bank[col] <= wbyte;
      end
   end

   assign sel_byte = col_byte[scan_y[ROW_W-1:3]];

   always_ff @(posedge clk)
      scan_pix <= sel_byte[scan_y[2:0]];

   assert_one_bank_R7 : assert property (@(posedge clk) $onehot0(we_vec));
endmodule

// File: rtl/mono_fb_ctrl.sv
module mono_fb_ctrl
   import fb_pkg::*;
#(
   parameter int              COLS     = 128,
   parameter int              PAGES    = 8,
   parameter int              OFS_W    = 12,
   parameter int              DW       = 32,
   parameter logic [OFS_W-1:0] OFS_MODE = 12'h1AC,
   parameter logic [OFS_W-1:0] OFS_INST = 12'h1BC,
   parameter logic [OFS_W-1:0] OFS_DATA = 12'h1C0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_wr,
   input  logic [OFS_W-1:0]         bus_addr,
   input  logic [DW-1:0]            bus_wdata,
   output logic [DW-1:0]            bus_rdata,
   input  logic [$clog2(COLS)-1:0]  scan_x,
   input  logic [$clog2(PAGES)+2:0] scan_y,
   output logic                     scan_pix
);
   localparam int COL_W  = $clog2(COLS);
   localparam int PAGE_W = $clog2(PAGES);

   if (COLS < 2 || (COLS & (COLS - 1)) != 0) begin : g_bad_cols
      $error("COLS must be a power of two of at least 2");
   end
   if (PAGES < 2 || PAGES > 8 || (PAGES & (PAGES - 1)) != 0) begin : g_bad_pages
      $error("PAGES must be 2, 4 or 8");
   end
   if (DW != 32) begin : g_bad_dw
      $error("DW must be 32");
   end

   fb_mode_e              mode;
   logic [PAGE_W-1:0]     page;
   logic [COL_W-1:0]      col;
   logic                  store_en;
   logic                  mode_wr, inst_wr, data_wr;

   assign mode_wr = bus_wr && bus_addr == OFS_MODE;
   assign inst_wr = bus_wr && bus_addr == OFS_INST;
   assign data_wr = bus_wr && bus_addr == OFS_DATA;

   fb_mode_reg #(.DW(DW)) u_mode (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (mode_wr),
      .wdata (bus_wdata),
      .mode  (mode)
   );

   fb_cursor #(.COLS(COLS), .PAGES(PAGES), .DW(DW)) u_cursor (
      .clk      (clk),
      .rst_n    (rst_n),
      .inst_wr  (inst_wr),
      .data_wr  (data_wr),
      .wdata    (bus_wdata),
      .mode     (mode),
      .page     (page),
      .col      (col),
      .store_en (store_en)
   );

   fb_store #(.COLS(COLS), .PAGES(PAGES)) u_store (
      .clk      (clk),
      .we       (store_en),
      .page     (page),
      .col      (col),
      .wbyte    (bus_wdata[7:0]),
      .scan_x   (scan_x),
      .scan_y   (scan_y),
      .scan_pix (scan_pix)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == OFS_MODE) begin
         case (mode)
            FB_MODE_DATA: bus_rdata = DW'(FB_DATA_WORD);
            FB_MODE_CMD:  bus_rdata = DW'(FB_CMD_WORD);
            default:      bus_rdata = '0;
         endcase
      end
   end

   assert_other_reads_zero_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr != OFS_MODE) |-> bus_rdata == '0);

   assert_store_needs_data_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode != FB_MODE_DATA) |-> !store_en);

   assert_reset_invalid_R1 : assert property (@(posedge clk)
      !rst_n |=> mode == FB_MODE_INVALID);
endmodule

// File: tb/test_mono_fb_ctrl.sv
module test_mono_fb_ctrl;
   localparam logic [11:0] A_IRQC = 12'h180;
   localparam logic [11:0] A_IRQS = 12'h184;
   localparam logic [11:0] A_MODE = 12'h1AC;
   localparam logic [11:0] A_INST = 12'h1BC;
   localparam logic [11:0] A_DATA = 12'h1C0;
   localparam logic [31:0] W_DATA = 32'h0010_0011;
   localparam logic [31:0] W_CMD  = 32'h0010_4011;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [6:0]  scan_x = '0;
   logic [5:0]  scan_y = '0;
   logic        scan_pix;
   int          nchk = 0;
   int          nbad = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   mono_fb_ctrl i_mono_fb_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .scan_x(scan_x), .scan_y(scan_y), .scan_pix(scan_pix)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic hw(input logic [11:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
      bus_addr = a;
      #1;
      check(bus_rdata === exp, tag, bus_rdata, exp);
   endtask

   task automatic byte_chk(input int c, input int p, input logic [7:0] exp, input string tag);
      logic [7:0] b;
      for (int y = 0; y < 8; y++) begin
         scan_x = 7'(c); scan_y = 6'(p * 8 + y);
         @(negedge clk);
         b[y] = scan_pix;
      end
      check(b === exp, tag, {24'h0, b}, {24'h0, exp});
   endtask

   task automatic t_reset;
      rd_chk(A_MODE, 32'h0, "R1 mode after reset");
      hw(A_MODE, W_DATA);
      hw(A_DATA, 32'hFFFF_FFA5);
      byte_chk(0, 0, 8'hA5, "R1 cursor starts at page0 col0");
   endtask

   task automatic t_modes;
      hw(A_MODE, W_DATA);
      rd_chk(A_MODE, W_DATA, "R2 data mode readback");
      hw(A_MODE, W_CMD);
      rd_chk(A_MODE, W_CMD, "R3 command mode readback");
      hw(A_MODE, 32'h0010_0010);
      rd_chk(A_MODE, 32'h0, "R4 near-miss word invalid");
      hw(A_MODE, W_CMD);
      hw(A_MODE, 32'h8010_4011);
      rd_chk(A_MODE, 32'h0, "R4 extra high bit invalid");
   endtask

   task automatic t_reads;
      hw(A_MODE, W_DATA);
      rd_chk(A_IRQC, 32'h0, "R11 offset 0x180");
      rd_chk(A_IRQS, 32'h0, "R11 offset 0x184");
      rd_chk(A_INST, 32'h0, "R11 offset 0x1BC");
      rd_chk(A_DATA, 32'h0, "R11 offset 0x1C0");
      rd_chk(12'h000, 32'h0, "R11 offset 0x000");
   endtask

   task automatic t_store;
      hw(A_MODE, W_DATA);
      hw(A_INST, 32'hB3);
      hw(A_DATA, 32'h01);
      hw(A_DATA, 32'h80);
      hw(A_DATA, 32'hFF);
      byte_chk(0, 3, 8'h01, "R7 page3 col0");
      byte_chk(1, 3, 8'h80, "R7 page3 col1");
      byte_chk(2, 3, 8'hFF, "R7 page3 col2");
      scan_x = 7'd1; scan_y = 6'd31; @(negedge clk);
      check(scan_pix === 1'b1, "R10 pixel (1,31) lit", {31'h0, scan_pix}, 32'h1);
      scan_x = 7'd1; scan_y = 6'd24; @(negedge clk);
      check(scan_pix === 1'b0, "R10 pixel (1,24) dark", {31'h0, scan_pix}, 32'h0);
   endtask

   task automatic t_inst_reg;
      hw(A_MODE, W_DATA);
      hw(A_INST, 32'hB4);
      hw(A_DATA, 32'h11);
      hw(A_INST, 32'hB8);
      hw(A_INST, 32'h1B4);
      hw(A_DATA, 32'h22);
      byte_chk(1, 4, 8'h22, "R5 invalid instruction ignored");
      hw(A_INST, 32'hB4);
      hw(A_DATA, 32'h33);
      byte_chk(0, 4, 8'h33, "R5 reselect resets column");
   endtask

   task automatic t_wrap;
      hw(A_MODE, W_DATA);
      hw(A_INST, 32'hB5);
      for (int i = 0; i < 130; i++) hw(A_DATA, 32'(i ^ 8'h5A));
      byte_chk(0, 5, 8'(128 ^ 8'h5A), "R8 wrap overwrites col0");
      byte_chk(1, 5, 8'(129 ^ 8'h5A), "R8 wrap overwrites col1");
      byte_chk(127, 5, 8'(127 ^ 8'h5A), "R8 col127 kept");
   endtask

   task automatic t_cmd_data;
      hw(A_MODE, W_DATA);
      hw(A_INST, 32'hB2);
      hw(A_DATA, 32'h00);
      hw(A_DATA, 32'h00);
      hw(A_MODE, W_CMD);
      hw(A_DATA, 32'hB2);
      hw(A_DATA, 32'h55);
      hw(A_MODE, W_DATA);
      hw(A_DATA, 32'h3C);
      byte_chk(0, 2, 8'h3C, "R6 page select via data reg");
      byte_chk(1, 2, 8'h00, "R6 non-page command stored nothing");
   endtask

   task automatic t_invalid;
      hw(A_MODE, 32'h1234);
      hw(A_DATA, 32'hFF);
      hw(A_DATA, 32'hEE);
      byte_chk(1, 2, 8'h00, "R9 invalid mode write ignored");
      hw(A_MODE, W_DATA);
      hw(A_DATA, 32'h81);
      byte_chk(1, 2, 8'h81, "R9 cursor not moved in invalid mode");
   endtask

   task automatic t_concurrent;
      hw(A_MODE, W_DATA);
      hw(A_INST, 32'hB6);
      for (int i = 0; i < 4; i++) begin
         bus_wr = 1'b1; bus_addr = A_DATA; bus_wdata = 32'(8'h10 + i);
         scan_x = 7'd0; scan_y = 6'(24 + i);
         @(negedge clk);
         check(scan_pix === (i == 0), "R12 scan during writes",
               {31'h0, scan_pix}, {31'h0, (i == 0)});
      end
      bus_wr = 1'b0;
      for (int i = 0; i < 4; i++)
         byte_chk(i, 6, 8'(8'h10 + i), "R12 writes landed");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_modes;
      t_reads;
      t_store;
      t_inst_reg;
      t_wrap;
      t_cmd_data;
      t_invalid;
      t_concurrent;
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nchk++; nbad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end
endmodule